// File: doc/BRIEF.md
# CAN Node Fault Confinement Unit

This block keeps the two error counters of a CAN node and derives from them the node's fault state: error-active, error-passive or bus-off. The protocol engine that sits beside it reports each detected error as a one-cycle pulse on the transmit or the receive side, together with a weight select of 1 or 8. It also reports each frame sent or received without error. The engine decides which protocol error earns which weight. The block answers with the counter values, the fault state, and the level the node's error flag must use: dominant while error-active, recessive otherwise.

Once the transmit counter passes 255 the node is bus-off. Error and success reports are then ignored. The node leaves bus-off only after the bit timing unit has reported 128 separate runs of 11 consecutive recessive bits. Counting of those runs is enabled in one of two ways: at once, when automatic recovery is enabled, or after software issues a recovery request while the node is already bus-off. When recovery completes, both counters return to zero and the node is error-active again.

Top module: `can_fault_conf`

## Requirements
- R1: A pulse on `tx_err_i` raises the transmit counter by 8 when `tx_err_heavy_i` is 1 and by 1 otherwise. The new value shows on `tec_o` in the cycle after the pulse.
- R2: A pulse on `rx_err_i` raises the receive counter by 8 when `rx_err_heavy_i` is 1 and by 1 otherwise. The receive counter saturates at 255.
- R3: A pulse on `tx_ok_i` or `rx_ok_i` lowers the matching counter by 1. The counter never goes below 0. If an error and a success reach the same counter in the same cycle, only the error is applied.
- R4: `state_o` reads 0 (error-active) while both counters are below 128. It reads 1 (error-passive) when either counter is 128 or more and the transmit counter is 255 or less.
- R5: `state_o` reads 2 (bus-off) from the cycle after the transmit counter exceeds 255. While bus-off, error and success pulses leave both counters unchanged.
- R6: `err_flag_recessive_o` is 0 in error-active and 1 in error-passive and bus-off.
- R7: With `auto_recover_i` at 1, a bus-off node counts bits flagged by `bit_valid_i`. A recessive bit (`bit_recessive_i` = 1) extends the current run. A dominant bit restarts the current run but keeps the runs already completed. Recovery completes on the 11th recessive bit of the 128th run.
- R8: With `auto_recover_i` at 0, recessive bits are not counted until `sw_recover_i` has been pulsed while the node is bus-off. Counting starts with the bit after that pulse. A pulse given outside bus-off has no effect.
- R9: In the cycle after recovery completes, both counters read 0 and `state_o` reads 0.
- R10: After reset, both counters are 0, `state_o` is 0 and `err_flag_recessive_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err_i | input | 1 | Transmit-side error event pulse |
| tx_err_heavy_i | input | 1 | Weight select for tx_err_i: 1 adds 8, 0 adds 1 |
| rx_err_i | input | 1 | Receive-side error event pulse |
| rx_err_heavy_i | input | 1 | Weight select for rx_err_i: 1 adds 8, 0 adds 1 |
| tx_ok_i | input | 1 | Frame sent without error |
| rx_ok_i | input | 1 | Frame received without error |
| bit_valid_i | input | 1 | One bit has been sampled this cycle |
| bit_recessive_i | input | 1 | Level of the sampled bit, 1 = recessive |
| auto_recover_i | input | 1 | Enables automatic bus-off recovery |
| sw_recover_i | input | 1 | Software recovery request pulse |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| state_o | output | 2 | 0 error-active, 1 error-passive, 2 bus-off |
| err_flag_recessive_o | output | 1 | Error flag level to use: 1 recessive, 0 dominant |

## Verification
Every result is due one clock edge after the stimulus that causes it. This holds for a counter step, a change of fault state, the entry into bus-off and the clear on recovery, because the state and the flag level are decoded directly from the registered counters. The bench drives each input just after a rising edge and keeps it for one cycle. A behavioural model advances on that same rising edge and is compared with all four outputs at the following falling edge. Directed checks sample just after the edge that took the last pulse or bit. These include the 1408th recessive bit and the recovery request being held off outside bus-off.

// File: rtl/can_fc_pkg.sv
// Package: shared fault state encoding for the CAN fault confinement unit.
// Assumes: encodings are visible on the top-level state port and must not change.
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;
endpackage

// File: rtl/fc_err_counter.sv
// Module: saturating error counter with a two-weight increment and a floored decrement.
// Assumes: clr_i has priority over inc_i, and inc_i has priority over dec_i.
// The caller gates inc_i and dec_i when the counter must stay frozen.
module fc_err_counter #(
    parameter int W     = 8,
    parameter int LIGHT = 1,
    parameter int HEAVY = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         heavy_i,
    input  logic         dec_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W:0]   SAT    = {1'b0, {W{1'b1}}};
    localparam logic [W:0]   STEP_L = (W+1)'(LIGHT);
    localparam logic [W:0]   STEP_H = (W+1)'(HEAVY);
    localparam logic [W-1:0] HEAD   = {W{1'b1}} - W'(HEAVY);

    logic [W-1:0] cnt_q, cnt_d;
    logic [W:0]   sum;

    // Next-value selection: clear, weighted saturating add, or floored decrement.
    always_comb begin
        sum   = {1'b0, cnt_q} + (heavy_i ? STEP_H : STEP_L);
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i)
            cnt_d = (sum > SAT) ? SAT[W-1:0] : sum[W-1:0];
        else if (dec_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !dec_i && !clr_i) |=> $stable(cnt_o)); // R5
    AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && cnt_o < HEAD) |=> (cnt_o > $past(cnt_o))); // R1
    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i && !clr_i && cnt_o == '0) |=> (cnt_o == '0)); // R3
    AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0)); // R9
endmodule

// File: rtl/fc_busoff_recovery.sv
// Module: counts runs of consecutive recessive bits while the node is bus-off.
// It flags completion on the last bit of the final run.
// Assumes: busoff_i drops in the cycle after done_o, and that drop clears all state here.
module fc_busoff_recovery #(
    parameter int RUN_LEN   = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busoff_i,
    input  logic auto_i,
    input  logic sw_req_i,
    input  logic bit_valid_i,
    input  logic bit_rec_i,
    output logic done_o
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam int CNT_W = $clog2(RUN_COUNT + 1);
    localparam logic [RUN_W-1:0] RUN_LAST  = RUN_W'(RUN_LEN - 1);
    localparam logic [CNT_W-1:0] RUNS_LAST = CNT_W'(RUN_COUNT - 1);

    logic [RUN_W-1:0] run_q;
    logic [CNT_W-1:0] runs_q;
    logic             arm_q;
    logic             armed, run_end;

    // Counting is enabled by the automatic setting or a latched software request.
    assign armed   = busoff_i && (auto_i || arm_q);
    assign run_end = armed && bit_valid_i && bit_rec_i && (run_q == RUN_LAST);
    assign done_o  = run_end && (runs_q == RUNS_LAST);

    // Run and run-total counters, plus the software arm latch.
    always_ff @(posedge clk) begin
        if (!rst_n || !busoff_i) begin
            run_q  <= '0;
            runs_q <= '0;
            arm_q  <= 1'b0;
        end else begin
            if (sw_req_i) arm_q <= 1'b1;
            if (armed && bit_valid_i) begin
                if (!bit_rec_i) begin
                    run_q <= '0;
                end else if (run_end) begin
                    run_q  <= '0;
                    runs_q <= runs_q + 1'b1;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_LAST); // R7
    AST_DOMINANT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bit_valid_i && !bit_rec_i) |=> (run_q == '0)); // R7
    AST_UNARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busoff_i && !armed) |=> ($stable(runs_q) && $stable(run_q))); // R8
    AST_CLEAR_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !busoff_i |=> (runs_q == '0 && !arm_q)); // R8
endmodule

// File: rtl/can_fault_conf.sv
// Module: CAN fault confinement top. It holds both error counters, decodes the fault
// state and the error flag level, and runs bus-off recovery.
// Assumes: the caller chooses the weight of each error event. Bus-off is decoded
// from the transmit counter passing its upper half.
module can_fault_conf
    import can_fc_pkg::*;
#(
    parameter int TEC_W     = 9,
    parameter int REC_W     = 8,
    parameter int RUN_LEN   = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err_i,
    input  logic             tx_err_heavy_i,
    input  logic             rx_err_i,
    input  logic             rx_err_heavy_i,
    input  logic             tx_ok_i,
    input  logic             rx_ok_i,
    input  logic             bit_valid_i,
    input  logic             bit_recessive_i,
    input  logic             auto_recover_i,
    input  logic             sw_recover_i,
    output logic [TEC_W-1:0] tec_o,
    output logic [REC_W-1:0] rec_o,
    output logic [1:0]       state_o,
    output logic             err_flag_recessive_o
);
    localparam logic [TEC_W-1:0] TEC_PASSIVE = TEC_W'(1 << (REC_W - 1));
    localparam logic [REC_W-1:0] REC_PASSIVE = REC_W'(1 << (REC_W - 1));
    localparam logic [TEC_W-1:0] TEC_BUSOFF  = TEC_W'(1 << (TEC_W - 1));
    localparam logic [TEC_W-1:0] TEC_NEAR    = TEC_BUSOFF - TEC_W'(8);

    logic      bus_off, rec_done;
    fc_state_e st;

    assign bus_off = (tec_o >= TEC_BUSOFF);

    fc_err_counter #(.W(TEC_W), .LIGHT(1), .HEAVY(8)) u_tec (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (tx_err_i && !bus_off),
        .heavy_i (tx_err_heavy_i),
        .dec_i   (tx_ok_i && !bus_off),
        .clr_i   (rec_done),
        .cnt_o   (tec_o)
    );

    fc_err_counter #(.W(REC_W), .LIGHT(1), .HEAVY(8)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (rx_err_i && !bus_off),
        .heavy_i (rx_err_heavy_i),
        .dec_i   (rx_ok_i && !bus_off),
        .clr_i   (rec_done),
        .cnt_o   (rec_o)
    );

    fc_busoff_recovery #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_recov (
        .clk         (clk),
        .rst_n       (rst_n),
        .busoff_i    (bus_off),
        .auto_i      (auto_recover_i),
        .sw_req_i    (sw_recover_i),
        .bit_valid_i (bit_valid_i),
        .bit_rec_i   (bit_recessive_i),
        .done_o      (rec_done)
    );

    // Fault state decode, with bus-off taking priority over the passive thresholds.
    always_comb begin
        if (bus_off)
            st = FC_BUSOFF;
        else if (tec_o >= TEC_PASSIVE || rec_o >= REC_PASSIVE)
            st = FC_PASSIVE;
        else
            st = FC_ACTIVE;
    end

    assign state_o              = st;
    assign err_flag_recessive_o = (st != FC_ACTIVE);

    AST_FROZEN_IN_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == FC_BUSOFF && !rec_done) |=> ($stable(tec_o) && $stable(rec_o))); // R5
    AST_ENTER_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != FC_BUSOFF && tx_err_i && tx_err_heavy_i && tec_o >= TEC_NEAR)
        |=> (state_o == FC_BUSOFF)); // R5
    AST_RECOVERY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == FC_BUSOFF) |=> (state_o == FC_BUSOFF) || (tec_o == '0 && rec_o == '0)); // R9
    AST_ACTIVE_DOMINANT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tec_o < TEC_PASSIVE && rec_o < REC_PASSIVE) |-> !err_flag_recessive_o); // R6
endmodule

// File: tb/can_fault_conf_tb.sv
// Bench: a behavioural model stepped on each rising edge and compared on each falling
// edge, plus directed checks at the requirement boundaries.
module can_fault_conf_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_err = 0, tx_heavy = 0, rx_err = 0, rx_heavy = 0, tx_ok = 0, rx_ok = 0;
    logic bit_valid = 0, bit_rec = 0, auto_rec = 0, sw_req = 0;
    logic [8:0] tec;
    logic [7:0] rec;
    logic [1:0] state;
    logic       flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_en = 0;

    // Model state
    int m_tec = 0, m_rec = 0, m_run = 0, m_runs = 0;
    bit m_arm = 0;

    always #10 clk = ~clk;

    can_fault_conf u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_err_i(tx_err), .tx_err_heavy_i(tx_heavy),
        .rx_err_i(rx_err), .rx_err_heavy_i(rx_heavy),
        .tx_ok_i(tx_ok), .rx_ok_i(rx_ok),
        .bit_valid_i(bit_valid), .bit_recessive_i(bit_rec),
        .auto_recover_i(auto_rec), .sw_recover_i(sw_req),
        .tec_o(tec), .rec_o(rec), .state_o(state), .err_flag_recessive_o(flag)
    );

    function automatic int exp_state();
        if (m_tec > 255) return 2;
        if (m_tec >= 128 || m_rec >= 128) return 1;
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        bit bo, armed, done;
        if (!rst_n) begin
            m_tec = 0; m_rec = 0; m_run = 0; m_runs = 0; m_arm = 0;
        end else begin
            bo    = (m_tec > 255);
            armed = bo && (auto_rec || m_arm);
            done  = 0;
            if (!bo) begin
                m_run = 0; m_runs = 0; m_arm = 0;
            end else begin
                if (armed && bit_valid) begin
                    if (!bit_rec) m_run = 0;
                    else begin
                        m_run++;
                        if (m_run == 11) begin
                            m_run = 0;
                            m_runs++;
                            if (m_runs == 128) done = 1;
                        end
                    end
                end
                if (sw_req) m_arm = 1;
            end
            if (done) begin
                m_tec = 0; m_rec = 0;
            end else if (!bo) begin
                if (tx_err) m_tec = (m_tec + (tx_heavy ? 8 : 1) > 511) ? 511 : m_tec + (tx_heavy ? 8 : 1);
                else if (tx_ok && m_tec > 0) m_tec--;
                if (rx_err) m_rec = (m_rec + (rx_heavy ? 8 : 1) > 255) ? 255 : m_rec + (rx_heavy ? 8 : 1);
                else if (rx_ok && m_rec > 0) m_rec--;
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            check(tec == m_tec, "R1 tec", tec, m_tec);
            check(rec == m_rec, "R2 rec", rec, m_rec);
            check(state == exp_state(), "R4 state", state, exp_state());
            check(flag == (exp_state() != 0), "R6 flag", flag, exp_state() != 0);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic pulse(input bit te, input bit th, input bit re, input bit rh,
                         input bit to, input bit ro);
        @(posedge clk); #2;
        tx_err = te; tx_heavy = th; rx_err = re; rx_heavy = rh; tx_ok = to; rx_ok = ro;
        @(posedge clk); #2;
        tx_err = 0; tx_heavy = 0; rx_err = 0; rx_heavy = 0; tx_ok = 0; rx_ok = 0;
    endtask

    task automatic bits(input int n, input bit v);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            bit_valid = 1; bit_rec = v;
        end
        @(posedge clk); #2;
        bit_valid = 0; bit_rec = 0;
    endtask

    task automatic sw_pulse();
        @(posedge clk); #2; sw_req = 1;
        @(posedge clk); #2; sw_req = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cmp_en = 1;
        // R10: reset state
        check(tec == 0 && rec == 0, "R10 counters", tec + rec, 0);
        check(state == 0 && flag == 0, "R10 state", state, 0);

        // R1: light and heavy transmit errors
        pulse(1,0,0,0,0,0); pulse(1,0,0,0,0,0); pulse(1,0,0,0,0,0);
        check(tec == 3, "R1 light", tec, 3);
        pulse(1,1,0,0,0,0);
        check(tec == 11, "R1 heavy", tec, 11);
        // R2: receive errors
        pulse(0,0,1,1,0,0); pulse(0,0,1,0,0,0);
        check(rec == 9, "R2 weights", rec, 9);
        // R3: decrement, error wins, floor
        pulse(0,0,0,0,1,1);
        check(tec == 10 && rec == 8, "R3 decrement", tec, 10);
        pulse(1,0,0,0,1,0);
        check(tec == 11, "R3 error wins", tec, 11);
        for (int i = 0; i < 12; i++) pulse(0,0,0,0,1,1);
        check(tec == 0 && rec == 0, "R3 floor", tec + rec, 0);

        // R4/R6: receive side to passive, then saturate (R2)
        for (int i = 0; i < 15; i++) pulse(0,0,1,1,0,0);
        check(state == 0 && rec == 120, "R4 still active", state, 0);
        pulse(0,0,1,1,0,0);
        check(state == 1, "R4 passive", state, 1);
        check(flag == 1, "R6 passive flag", flag, 1);
        for (int i = 0; i < 20; i++) pulse(0,0,1,1,0,0);
        check(rec == 255, "R2 saturate", rec, 255);
        for (int i = 0; i < 128; i++) pulse(0,0,0,0,0,1);
        check(state == 0 && rec == 127, "R4 back active", state, 0);

        // R5: transmit side to bus-off
        for (int i = 0; i < 32; i++) pulse(1,1,0,0,0,0);
        check(state == 2 && tec == 256, "R5 bus-off", state, 2);
        pulse(1,1,1,1,0,0); pulse(0,0,0,0,1,1);
        check(tec == 256 && rec == 127, "R5 frozen", tec, 256);
        check(flag == 1, "R6 bus-off flag", flag, 1);

        // R7: auto recovery with one dominant interruption
        auto_rec = 1;
        bits(5, 1); bits(1, 0);
        bits(128 * 11 - 1, 1);
        check(state == 2, "R7 one bit short", state, 2);
        bits(1, 1);
        check(state == 0, "R7 recovered", state, 0);
        check(tec == 0 && rec == 0, "R9 cleared", tec + rec, 0);

        // R8: software request path
        auto_rec = 0;
        sw_pulse();                       // outside bus-off: ignored
        for (int i = 0; i < 32; i++) pulse(1,1,0,0,0,0);
        check(state == 2, "R8 bus-off again", state, 2);
        bits(128 * 11 + 20, 1);
        check(state == 2, "R8 no count without request", state, 2);
        sw_pulse();
        bits(128 * 11 - 1, 1);
        check(state == 2, "R8 one bit short", state, 2);
        bits(1, 1);
        check(state == 0 && tec == 0, "R8 recovered", state, 0);

        repeat (3) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule